// File: doc/BRIEF.md
# Chained Front-End Readout Sequencer

This block drives a chain of multichannel front-end chips that share one analog output line towards an external converter. Each chip contributes one merged request, which is the OR of its channel discriminator flags. When any merged request is seen while the sequencer is idle, the block starts a readout. It raises a stop line at once to end time measurement in every channel. After a programmable settling delay, it raises a hold line to freeze the shaped amplitudes.

While hold is high, the sequencer walks the chain strictly one chip at a time. Inside each chip it steps through the channels. For every channel it requests two conversions: first the energy word, then the time word. A one-hot read token selects the chip whose output drives the shared line. Each conversion strobe carries the chip index, the channel index and an energy/time flag. Conversions are paced one every `WORD_CYC` clock cycles.

A busy level covers the whole sequence. A one-cycle done pulse marks its normal end. Requests that arrive while busy are ignored. A synchronous clear input abandons the sequence and returns to idle at once.

Top module: `rdseq_top`

## Requirements
- R1: `chip_req_o[k]` is, in the same cycle, the OR of the channel flags `hit_i[k*N_CH + c]` for c = 0..N_CH-1.
- R2: When the block is idle, `clear_i` is low and any bit of `chip_req_o` is high at a clock edge, then `busy_o` and `stop_o` are high in the following cycle. A request still present after a done pulse starts a new sequence this way.
- R3: `hold_o` rises exactly D+1 cycles after `stop_o` rises, where D is the value of `hold_dly_i` sampled at the triggering edge. `hold_o` then stays high until the sequence ends. `stop_o` stays high for the whole sequence.
- R4: Words come out in this order: chip 0 up to chip N_CHIPS-1, and within each chip channel 0 up to N_CH-1. Each channel gives an energy word (`word_is_time_o`=0) followed by a time word (`word_is_time_o`=1). `word_chip_o` and `word_chan_o` give the indices of the word.
- R5: `word_valid_o` pulses once every WORD_CYC cycles. The first pulse is in the first cycle with `hold_o` high. There are exactly 2*N_CHIPS*N_CH pulses per complete sequence, and none while `hold_o` is low.
- R6: `token_o` is one-hot on the chip being read while `hold_o` is high, and zero otherwise. It moves to the next chip after the previous chip's last time word slot.
- R7: `done_o` is a single-cycle pulse in the cycle right after the last word slot. In that cycle `busy_o`, `stop_o`, `hold_o` and `token_o` are already low.
- R8: Requests that arrive while `busy_o` is high do not alter or restart the running sequence.
- R9: A high `clear_i` at a clock edge makes `busy_o`, `stop_o`, `hold_o`, `token_o`, `word_valid_o` and `done_o` low in the next cycle. While `clear_i` is held high, no sequence starts.
- R10: After synchronous reset (`rst_n` low), every output except `chip_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Abandon the sequence and return to idle |
| hit_i | input | N_CHIPS*N_CH | Channel discriminator flags, chip-major |
| hold_dly_i | input | DLY_W | Cycles from stop to hold, minus one |
| chip_req_o | output | N_CHIPS | Merged request per chip |
| stop_o | output | 1 | Ends time measurement in all channels |
| hold_o | output | 1 | Freezes pulse amplitudes on its rising edge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| token_o | output | N_CHIPS | One-hot read token along the chain |
| word_valid_o | output | 1 | Conversion strobe for the external converter |
| word_chip_o | output | clog2(N_CHIPS) | Chip index of the current word |
| word_chan_o | output | clog2(N_CH) | Channel index of the current word |
| word_is_time_o | output | 1 | 0 for an energy word, 1 for a time word |

## Verification
The properties assume that `hold_dly_i` stays constant while a sequence runs, and that `clear_i` is used only as a level abort, with no relation to the conversion slots. The bench changes `hold_dly_i` only while the block is idle. It applies clear both in idle and mid-sequence, so that both the clear path and the plain completion path are covered. Request patterns include single-cycle flags, flags held high across the done pulse (to force an immediate retrigger) and bursts on all channels during a readout. This keeps the check of the ignore-while-busy rule on real activity.

// File: rtl/rdseq_pkg.sv
// Shared types and helpers for the readout sequencer.
// Assumes: counts passed to idx_w are at least 1.
package rdseq_pkg;

    // Phases of one readout sequence
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_READ = 2'd2
    } seq_state_e;

    // Index width for a count of n items (never zero)
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rdseq_req_merge.sv
// Merges channel discriminator flags into one request per chip,
// plus a single "any request" line for the control logic.
// Assumes: flags are synchronous to clk and chip-major ordered.
module rdseq_req_merge #(
    parameter int unsigned N_CHIPS = 9,
    parameter int unsigned N_CH    = 16
) (
    input  logic [N_CHIPS*N_CH-1:0] hit_i,
    output logic [N_CHIPS-1:0]      chip_req_o,
    output logic                    any_req_o
);

    // One OR tree per chip
    for (genvar k = 0; k < N_CHIPS; k++) begin : g_chip
        assign chip_req_o[k] = |hit_i[k*N_CH +: N_CH];
    end

    // Chain-wide request
    assign any_req_o = |chip_req_o;

endmodule

// File: rtl/rdseq_trig_ctrl.sv
// Sequence control: starts on a merged request, raises stop at once,
// raises hold after a programmable delay, and ends on the scan end
// pulse or on clear.
// Assumes: hold_dly_i is stable while a sequence runs.
module rdseq_trig_ctrl
    import rdseq_pkg::*;
#(
    parameter int unsigned DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             any_req_i,
    input  logic [DLY_W-1:0] hold_dly_i,
    input  logic             scan_end_i,
    output logic             busy_o,
    output logic             stop_o,
    output logic             hold_o,
    output logic             read_o,
    output logic             done_o
);

    seq_state_e       state_q;
    logic [DLY_W-1:0] dly_q;
    logic             stop_q;
    logic             hold_q;
    logic             done_q;

    // Sequence state, delay count and the stop/hold/done registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dly_q   <= '0;
            stop_q  <= 1'b0;
            hold_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (clear_i) begin
                state_q <= ST_IDLE;
                dly_q   <= '0;
                stop_q  <= 1'b0;
                hold_q  <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (any_req_i) begin
                            state_q <= ST_ARM;
                            stop_q  <= 1'b1;
                            dly_q   <= hold_dly_i;
                        end
                    end
                    ST_ARM: begin
                        if (dly_q == '0) begin
                            state_q <= ST_READ;
                            hold_q  <= 1'b1;
                        end else begin
                            dly_q <= dly_q - 1'b1;
                        end
                    end
                    ST_READ: begin
                        if (scan_end_i) begin
                            state_q <= ST_IDLE;
                            stop_q  <= 1'b0;
                            hold_q  <= 1'b0;
                            done_q  <= 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Status decoded from the phase
    assign busy_o = (state_q != ST_IDLE);
    assign read_o = (state_q == ST_READ);
    assign stop_o = stop_q;
    assign hold_o = hold_q;
    assign done_o = done_q;

endmodule

// File: rtl/rdseq_scan.sv
// Chain scanner: paces conversions, steps energy/time, channel and
// chip, and passes the one-hot read token down the chain.
// Assumes: run_i is low for at least one cycle between sequences,
// so every count restarts from zero.
module rdseq_scan
    import rdseq_pkg::*;
#(
    parameter int unsigned N_CHIPS  = 9,
    parameter int unsigned N_CH     = 16,
    parameter int unsigned WORD_CYC = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run_i,
    output logic                        strobe_o,
    output logic [idx_w(N_CHIPS)-1:0]   chip_o,
    output logic [idx_w(N_CH)-1:0]      chan_o,
    output logic                        is_time_o,
    output logic [N_CHIPS-1:0]          token_o,
    output logic                        end_o
);

    localparam int unsigned CHIP_W = idx_w(N_CHIPS);
    localparam int unsigned CH_W   = idx_w(N_CH);

    logic              pace_zero;
    logic              pace_last;
    logic              step;
    logic              chan_last;
    logic              chip_last;
    logic [CHIP_W-1:0] chip_q;
    logic [CH_W-1:0]   chan_q;
    logic              time_q;
    logic [N_CHIPS-1:0] tok_q;

    // Conversion pacing: with one cycle per word no counter is needed
    if (WORD_CYC <= 1) begin : g_nopace
        assign pace_zero = 1'b1;
        assign pace_last = 1'b1;
    end else begin : g_pace
        localparam int unsigned PW = idx_w(WORD_CYC);
        logic [PW-1:0] pace_q;
        // Slot counter inside one word period
        always_ff @(posedge clk) begin
            if (!rst_n || !run_i) begin
                pace_q <= '0;
            end else if (pace_q == PW'(WORD_CYC - 1)) begin
                pace_q <= '0;
            end else begin
                pace_q <= pace_q + 1'b1;
            end
        end
        assign pace_zero = (pace_q == '0);
        assign pace_last = (pace_q == PW'(WORD_CYC - 1));
    end

    assign step      = run_i && pace_last;
    assign chan_last = (chan_q == CH_W'(N_CH - 1));
    assign chip_last = (chip_q == CHIP_W'(N_CHIPS - 1));

    // Word position along the chain and the read token
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            chip_q <= '0;
            chan_q <= '0;
            time_q <= 1'b0;
            tok_q  <= N_CHIPS'(1);
        end else if (step) begin
            time_q <= ~time_q;
            if (time_q) begin
                if (chan_last) begin
                    chan_q <= '0;
                    chip_q <= chip_q + 1'b1;
                    tok_q  <= tok_q << 1;
                end else begin
                    chan_q <= chan_q + 1'b1;
                end
            end
        end
    end

    assign strobe_o  = run_i && pace_zero;
    assign chip_o    = chip_q;
    assign chan_o    = chan_q;
    assign is_time_o = time_q;
    assign token_o   = run_i ? tok_q : '0;
    assign end_o     = step && time_q && chan_last && chip_last;

endmodule

// File: rtl/rdseq_top.sv
// Readout sequencer for a chain of multichannel front-end chips on one
// shared analog line: request merge, stop/hold timing, chip-by-chip
// token scan with energy and time words per channel.
// Assumes: inputs synchronous to clk; hold_dly_i constant during a run.
module rdseq_top
    import rdseq_pkg::*;
#(
    parameter int unsigned N_CHIPS  = 9,
    parameter int unsigned N_CH     = 16,
    parameter int unsigned DLY_W    = 8,
    parameter int unsigned WORD_CYC = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear_i,
    input  logic [N_CHIPS*N_CH-1:0]     hit_i,
    input  logic [DLY_W-1:0]            hold_dly_i,
    output logic [N_CHIPS-1:0]          chip_req_o,
    output logic                        stop_o,
    output logic                        hold_o,
    output logic                        busy_o,
    output logic                        done_o,
    output logic [N_CHIPS-1:0]          token_o,
    output logic                        word_valid_o,
    output logic [idx_w(N_CHIPS)-1:0]   word_chip_o,
    output logic [idx_w(N_CH)-1:0]      word_chan_o,
    output logic                        word_is_time_o
);

    logic any_req;
    logic read_en;
    logic scan_end;

    rdseq_req_merge #(.N_CHIPS(N_CHIPS), .N_CH(N_CH)) u_merge (
        .hit_i      (hit_i),
        .chip_req_o (chip_req_o),
        .any_req_o  (any_req)
    );

    rdseq_trig_ctrl #(.DLY_W(DLY_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .any_req_i  (any_req),
        .hold_dly_i (hold_dly_i),
        .scan_end_i (scan_end),
        .busy_o     (busy_o),
        .stop_o     (stop_o),
        .hold_o     (hold_o),
        .read_o     (read_en),
        .done_o     (done_o)
    );

    rdseq_scan #(.N_CHIPS(N_CHIPS), .N_CH(N_CH), .WORD_CYC(WORD_CYC)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (read_en),
        .strobe_o  (word_valid_o),
        .chip_o    (word_chip_o),
        .chan_o    (word_chan_o),
        .is_time_o (word_is_time_o),
        .token_o   (token_o),
        .end_o     (scan_end)
    );

endmodule

// File: rtl/rdseq_chk.sv
// Property checker for rdseq_top, attached by bind.
// Assumes: same parameter values as the bound instance.
module rdseq_chk
    import rdseq_pkg::*;
#(
    parameter int unsigned N_CHIPS = 9,
    parameter int unsigned N_CH    = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      clear_i,
    input logic [N_CHIPS-1:0]        chip_req_o,
    input logic                      stop_o,
    input logic                      hold_o,
    input logic                      busy_o,
    input logic                      done_o,
    input logic [N_CHIPS-1:0]        token_o,
    input logic                      word_valid_o,
    input logic [idx_w(N_CHIPS)-1:0] word_chip_o
);

    // R2
    start_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !clear_i && (|chip_req_o)) |=> (busy_o && stop_o));

    // R3
    hold_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> (busy_o && stop_o));

    // R3
    hold_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_o) |-> (done_o || $past(clear_i)));

    // R5
    strobe_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> hold_o);

    // R6
    token_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(token_o));

    // R6
    token_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> token_o[word_chip_o]);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !hold_o && !stop_o && token_o == '0 && $past(hold_o)));

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_o && !clear_i) |=> (stop_o || done_o));

    // R9
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!busy_o && !hold_o && !stop_o && !done_o && !word_valid_o && token_o == '0));

endmodule

bind rdseq_top rdseq_chk #(.N_CHIPS(N_CHIPS), .N_CH(N_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (clear_i),
    .chip_req_o   (chip_req_o),
    .stop_o       (stop_o),
    .hold_o       (hold_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .token_o      (token_o),
    .word_valid_o (word_valid_o),
    .word_chip_o  (word_chip_o)
);

// File: tb/sim_rdseq_top.sv
// Bench for rdseq_top: behavioural timeline model compared every cycle,
// plus directed checks for reset, merge, retrigger, ignore and clear.
module sim_rdseq_top;

    localparam int NC  = 9;
    localparam int NCH = 16;
    localparam int WC  = 4;
    localparam int NW  = 2 * NC * NCH;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clear_i = 1'b0;
    logic [NC*NCH-1:0] hit_i = '0;
    logic [7:0]        hold_dly_i = 8'd3;
    logic [NC-1:0]     chip_req_o;
    logic              stop_o, hold_o, busy_o, done_o;
    logic [NC-1:0]     token_o;
    logic              word_valid_o;
    logic [3:0]        word_chip_o;
    logic [3:0]        word_chan_o;
    logic              word_is_time_o;

    int total = 0;
    int bad   = 0;
    int strobes = 0;
    bit finished = 0;

    // Model: busy flag, edges since trigger, captured delay, done pulse
    bit m_busy = 0;
    int m_t    = 0;
    int m_d    = 0;
    bit m_done = 0;

    always #2.5 clk = ~clk;

    rdseq_top #(.N_CHIPS(NC), .N_CH(NCH), .DLY_W(8), .WORD_CYC(WC)) u0 (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .hit_i(hit_i),
        .hold_dly_i(hold_dly_i), .chip_req_o(chip_req_o), .stop_o(stop_o),
        .hold_o(hold_o), .busy_o(busy_o), .done_o(done_o), .token_o(token_o),
        .word_valid_o(word_valid_o), .word_chip_o(word_chip_o),
        .word_chan_o(word_chan_o), .word_is_time_o(word_is_time_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NC-1:0] exp_req();
        logic [NC-1:0] r = '0;
        for (int k = 0; k < NC; k++)
            for (int c = 0; c < NCH; c++)
                if (hit_i[k*NCH + c]) r[k] = 1'b1;
        return r;
    endfunction

    // Model update on every edge
    always @(posedge clk) begin
        m_done = 0;
        if (!rst_n || clear_i) begin
            m_busy = 0;
            m_t = 0;
        end else if (!m_busy) begin
            if (|hit_i) begin
                m_busy = 1;
                m_t = 0;
                m_d = int'(hold_dly_i);
            end
        end else begin
            m_t++;
            if (m_t == m_d + 1 + NW*WC) begin
                m_busy = 0;
                m_done = 1;
            end
        end
    end

    // Per-cycle comparison, one time unit after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            bit e_hold, e_valid;
            int rel, w, e_chip;
            logic [NC-1:0] e_tok;
            e_hold = m_busy && (m_t >= m_d + 1);
            rel    = m_t - (m_d + 1);
            w      = e_hold ? rel / WC : 0;
            e_chip = w / (2*NCH);
            e_valid = e_hold && (rel % WC == 0);
            e_tok  = e_hold ? NC'(1) << e_chip : '0;
            if (word_valid_o) strobes++;
            chk(chip_req_o == exp_req(), "R1 chip_req", chip_req_o, exp_req());
            chk(busy_o == m_busy && stop_o == m_busy, "R2 busy/stop", {busy_o, stop_o}, {m_busy, m_busy});
            chk(hold_o == e_hold, "R3 hold", hold_o, e_hold);
            chk(word_valid_o == e_valid, "R5 strobe", word_valid_o, e_valid);
            chk(token_o == e_tok, "R6 token", token_o, e_tok);
            chk(done_o == m_done, "R7 done", done_o, m_done);
            if (e_valid) begin
                chk(word_chip_o == e_chip && word_chan_o == (w/2) % NCH && word_is_time_o == w % 2,
                    "R4 word fields", {word_chip_o, word_chan_o, word_is_time_o},
                    {4'(e_chip), 4'((w/2) % NCH), 1'(w % 2)});
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10 reset state
        chk({stop_o, hold_o, busy_o, done_o, word_valid_o} == 5'b0 && token_o == '0,
            "R10 reset outputs", {stop_o, hold_o, busy_o, done_o, word_valid_o}, 0);
        rst_n = 1'b1;
        // R1 merge patterns with clear held (R9 keeps idle)
        clear_i = 1'b1;
        for (int k = 0; k < NC; k++) begin
            hit_i = '0;
            hit_i[k*NCH + (k*5) % NCH] = 1'b1;
            @(negedge clk);
            chk(chip_req_o == NC'(1) << k, "R1 single flag", chip_req_o, NC'(1) << k);
        end
        hit_i = '1;
        @(negedge clk);
        chk(chip_req_o == '1, "R1 all flags", chip_req_o, '1);
        chk(busy_o == 1'b0, "R9 clear blocks start", busy_o, 0);
        hit_i = '0;
        clear_i = 1'b0;
        @(negedge clk);

        // Run 1: one-cycle flag, burst of flags mid-run (R8)
        hold_dly_i = 8'd3;
        strobes = 0;
        hit_i[3*NCH + 7] = 1'b1;
        @(negedge clk);
        hit_i = '0;
        chk(busy_o && stop_o && !hold_o, "R2 start", {busy_o, stop_o, hold_o}, 3'b110);
        repeat (60) @(negedge clk);
        hit_i = '1;
        repeat (10) @(negedge clk);
        hit_i = '0;
        chk(busy_o && hold_o, "R8 burst ignored", {busy_o, hold_o}, 2'b11);
        wait_done();
        chk(done_o, "R7 done seen", done_o, 1);
        chk(strobes == NW, "R5 strobe count", strobes, NW);
        @(negedge clk);

        // Run 2: zero delay, flag held across done -> retrigger
        hold_dly_i = 8'd0;
        strobes = 0;
        hit_i[NC*NCH-1] = 1'b1;
        wait_done();
        chk(strobes == NW, "R5 strobe count d0", strobes, NW);
        @(negedge clk);
        chk(busy_o && stop_o, "R2 retrigger", {busy_o, stop_o}, 2'b11);
        hit_i = '0;
        repeat (100) @(negedge clk);
        // R9 clear mid-readout
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        chk(!busy_o && !hold_o && !stop_o && token_o == '0 && !word_valid_o && !done_o,
            "R9 clear", {busy_o, hold_o, stop_o}, 0);
        repeat (5) @(negedge clk);
        chk(!busy_o, "R9 stays idle", busy_o, 0);

        // Run 3: longer delay
        hold_dly_i = 8'd7;
        strobes = 0;
        hit_i[0] = 1'b1;
        @(negedge clk);
        hit_i = '0;
        wait_done();
        chk(strobes == NW, "R5 strobe count d7", strobes, NW);
        repeat (3) @(negedge clk);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule